// File: doc/BRIEF.md
# Exception Return Control Unit

This unit carries out the return-from-exception step of a CPU control path. When a return request arrives, it looks at the current-mode register, the ordinary saved-mode register, the ordinary return address, and the saved-mode and return-address registers used by TLB-refill handlers. It picks which pair to return through, rebuilds the current-mode register with the restored privilege level and interrupt enable, and produces the redirect target for fetch.

Bit 0 of the refill return-address register doubles as a flag meaning "a TLB-refill handler is active". When that flag is set, the return goes through the refill pair and the flag is written back as cleared. Every successful return also sets the linked-load state register. All of these CSR writes and the fetch redirect come out together in one cycle under one commit strobe. That cycle is the cue for the pipeline to flush the instructions that follow the return and to restart fetch.

A return request made while the core is not at privilege level 0 is refused. The unit raises a privilege-fault strobe instead and writes nothing.

Top module: `ertn_unit`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `commitValid`, `faultValid`, `refillAddrWe` and `llSet` are all 0.
- R2: In the current-mode register and in both saved-mode values, the privilege level sits in bits [1:0] and the interrupt enable in bit 2. When bit 0 of `refillAddr` is 1 on a committed return, `modeOut[1:0]` equals `refillPrev[1:0]` and `modeOut[2]` equals `refillPrev[2]`.
- R3: On a committed return with bit 0 of `refillAddr` set, `refillAddrWe` is 1, `refillAddrOut` equals `refillAddr` with bit 0 forced to 0, and `redirectPc` equals that same cleared value.
- R4: When bit 0 of `refillAddr` is 0 on a committed return, `modeOut[1:0]` and `modeOut[2]` come from `ordPrev`, `redirectPc` equals `ordAddr`, and `refillAddrWe` is 0.
- R5: Every committed return asserts `llSet`, meaning the linked-load state register is written to 1.
- R6: On a committed return, bits of `modeOut` above bit 2 equal the matching bits of `curMode`.
- R7: A request made while `curMode[1:0]` is not 0 raises `faultValid` and leaves `commitValid`, `refillAddrWe` and `llSet` at 0.
- R8: Results appear exactly one cycle after the request cycle, as single-cycle strobes. A cycle with no request gives no strobe in the next cycle.
- R9: `commitValid` and `faultValid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retReq | input | 1 | Exception-return request, one cycle per instruction |
| curMode | input | MODE_W | Current-mode register value |
| ordPrev | input | PLV_W+1 | Ordinary saved mode: {IE, PLV} |
| ordAddr | input | ADDR_W | Ordinary exception return address |
| refillPrev | input | PLV_W+1 | Refill saved mode: {IE, PLV} |
| refillAddr | input | ADDR_W | Refill return address; bit 0 is the refill-active flag |
| commitValid | output | 1 | Commit strobe for all writes and the redirect |
| faultValid | output | 1 | Privilege fault instead of a return |
| modeOut | output | MODE_W | New current-mode value |
| refillAddrWe | output | 1 | Write enable for the refill return-address register |
| refillAddrOut | output | ADDR_W | Refill return address with the flag cleared |
| llSet | output | 1 | Write 1 to the linked-load state register |
| redirectPc | output | ADDR_W | Fetch restart address |

## Verification
Choosing the wrong return source shows up in the commit cycle, one clock after the request. The privilege, interrupt enable and redirect address then differ from the pair the refill flag selects. A stale or sticky strobe register shows up one cycle later, as a strobe in a cycle that had no request, or as a commit and a fault together. Corrupted upper mode bits, or a flag that is not cleared in the written-back refill address, are visible on the same commit cycle.

// File: rtl/ertn_pkg.sv
package ertn_pkg;
  typedef struct packed {
    logic doCommit;
    logic doFault;
    logic useRefill;
  } ertnStrobe_t;
endpackage

// File: rtl/ertn_ctrl.sv
module ertn_ctrl
  import ertn_pkg::*;
#(
  parameter int PLV_W = 2
) (
  input  logic             retReq,
  input  logic [PLV_W-1:0] curPlv,
  input  logic             refillFlag,
  output ertnStrobe_t      strobe
);
  logic privOk;

  always_comb begin
    privOk           = (curPlv == '0);
    strobe.doCommit  = retReq && privOk;
    strobe.doFault   = retReq && !privOk;
    strobe.useRefill = refillFlag;
  end
endmodule

// File: rtl/ertn_datapath.sv
module ertn_datapath
  import ertn_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MODE_W = 9,
  parameter int PLV_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ertnStrobe_t       strobe,
  input  logic [MODE_W-1:0] curMode,
  input  logic [PLV_W:0]    ordPrev,
  input  logic [ADDR_W-1:0] ordAddr,
  input  logic [PLV_W:0]    refillPrev,
  input  logic [ADDR_W-1:0] refillAddr,
  output logic              commitValid,
  output logic              faultValid,
  output logic [MODE_W-1:0] modeOut,
  output logic              refillAddrWe,
  output logic [ADDR_W-1:0] refillAddrOut,
  output logic              llSet,
  output logic [ADDR_W-1:0] redirectPc
);
  localparam int IE_POS = PLV_W;

  logic [PLV_W:0]    srcPrev;
  logic [ADDR_W-1:0] clearedRefill;
  logic [ADDR_W-1:0] nextPc;
  logic [MODE_W-1:0] nextMode;

  always_comb begin
    srcPrev       = strobe.useRefill ? refillPrev : ordPrev;
    clearedRefill = {refillAddr[ADDR_W-1:1], 1'b0};
    nextPc        = strobe.useRefill ? clearedRefill : ordAddr;
    nextMode      = curMode;
    nextMode[PLV_W-1:0] = srcPrev[PLV_W-1:0];
    nextMode[IE_POS]    = srcPrev[IE_POS];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitValid  <= 1'b0;
      faultValid   <= 1'b0;
      refillAddrWe <= 1'b0;
      llSet        <= 1'b0;
    end else begin
      commitValid  <= strobe.doCommit;
      faultValid   <= strobe.doFault;
      refillAddrWe <= strobe.doCommit && strobe.useRefill;
      llSet        <= strobe.doCommit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeOut       <= '0;
      refillAddrOut <= '0;
      redirectPc    <= '0;
    end else if (strobe.doCommit) begin
      modeOut       <= nextMode;
      refillAddrOut <= clearedRefill;
      redirectPc    <= nextPc;
    end
  end
endmodule

// File: rtl/ertn_unit.sv
module ertn_unit
  import ertn_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MODE_W = 9,
  parameter int PLV_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retReq,
  input  logic [MODE_W-1:0] curMode,
  input  logic [PLV_W:0]    ordPrev,
  input  logic [ADDR_W-1:0] ordAddr,
  input  logic [PLV_W:0]    refillPrev,
  input  logic [ADDR_W-1:0] refillAddr,
  output logic              commitValid,
  output logic              faultValid,
  output logic [MODE_W-1:0] modeOut,
  output logic              refillAddrWe,
  output logic [ADDR_W-1:0] refillAddrOut,
  output logic              llSet,
  output logic [ADDR_W-1:0] redirectPc
);
  ertnStrobe_t strobe;

  ertn_ctrl #(.PLV_W(PLV_W)) ctrl (
    .retReq     (retReq),
    .curPlv     (curMode[PLV_W-1:0]),
    .refillFlag (refillAddr[0]),
    .strobe     (strobe)
  );

  ertn_datapath #(.ADDR_W(ADDR_W), .MODE_W(MODE_W), .PLV_W(PLV_W)) dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .curMode       (curMode),
    .ordPrev       (ordPrev),
    .ordAddr       (ordAddr),
    .refillPrev    (refillPrev),
    .refillAddr    (refillAddr),
    .commitValid   (commitValid),
    .faultValid    (faultValid),
    .modeOut       (modeOut),
    .refillAddrWe  (refillAddrWe),
    .refillAddrOut (refillAddrOut),
    .llSet         (llSet),
    .redirectPc    (redirectPc)
  );
endmodule

// File: rtl/ertn_checker.sv
module ertn_checker #(
  parameter int ADDR_W = 32,
  parameter int MODE_W = 9,
  parameter int PLV_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              retReq,
  input logic [MODE_W-1:0] curMode,
  input logic [ADDR_W-1:0] refillAddr,
  input logic              commitValid,
  input logic              faultValid,
  input logic [MODE_W-1:0] modeOut,
  input logic              refillAddrWe,
  input logic [ADDR_W-1:0] refillAddrOut,
  input logic              llSet,
  input logic [ADDR_W-1:0] redirectPc
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(commitValid && faultValid));

  assert_ll_on_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> llSet);

  assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (!refillAddrWe && !llSet));

  assert_flag_cleared_R3: assert property (@(posedge clk) disable iff (!rstN)
    refillAddrWe |-> (refillAddrOut[0] == 1'b0 && redirectPc == refillAddrOut));

  assert_upper_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && commitValid) |-> (modeOut[MODE_W-1:PLV_W+1] == $past(curMode[MODE_W-1:PLV_W+1])));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ((commitValid || faultValid) == $past(retReq)));

  assert_refill_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && commitValid) |-> (refillAddrWe == $past(refillAddr[0])));
endmodule

bind ertn_unit ertn_checker #(.ADDR_W(ADDR_W), .MODE_W(MODE_W), .PLV_W(PLV_W)) chk (
  .clk           (clk),
  .rstN          (rstN),
  .retReq        (retReq),
  .curMode       (curMode),
  .refillAddr    (refillAddr),
  .commitValid   (commitValid),
  .faultValid    (faultValid),
  .modeOut       (modeOut),
  .refillAddrWe  (refillAddrWe),
  .refillAddrOut (refillAddrOut),
  .llSet         (llSet),
  .redirectPc    (redirectPc)
);

// File: tb/ertn_unit_test.sv
module ertn_unit_test;
  localparam int ADDR_W = 32;
  localparam int MODE_W = 9;
  localparam int PLV_W  = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              retReq = 1'b0;
  logic [MODE_W-1:0] curMode = '0;
  logic [PLV_W:0]    ordPrev = '0;
  logic [ADDR_W-1:0] ordAddr = '0;
  logic [PLV_W:0]    refillPrev = '0;
  logic [ADDR_W-1:0] refillAddr = '0;
  logic              commitValid, faultValid, refillAddrWe, llSet;
  logic [MODE_W-1:0] modeOut;
  logic [ADDR_W-1:0] refillAddrOut, redirectPc;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ertn_unit #(.ADDR_W(ADDR_W), .MODE_W(MODE_W), .PLV_W(PLV_W)) uut (
    .clk(clk), .rstN(rstN), .retReq(retReq), .curMode(curMode),
    .ordPrev(ordPrev), .ordAddr(ordAddr), .refillPrev(refillPrev),
    .refillAddr(refillAddr), .commitValid(commitValid), .faultValid(faultValid),
    .modeOut(modeOut), .refillAddrWe(refillAddrWe), .refillAddrOut(refillAddrOut),
    .llSet(llSet), .redirectPc(redirectPc)
  );

  function automatic logic [MODE_W-1:0] expMode(input logic [MODE_W-1:0] cm,
      input logic [PLV_W:0] op, input logic [PLV_W:0] rp, input logic fl);
    logic [PLV_W:0] src = fl ? rp : op;
    return {cm[MODE_W-1:PLV_W+1], src};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkIdle(input string tag);
    check({tag, " commitValid"}, 64'(commitValid), 64'd0);
    check({tag, " faultValid"}, 64'(faultValid), 64'd0);
    check({tag, " refillAddrWe"}, 64'(refillAddrWe), 64'd0);
    check({tag, " llSet"}, 64'(llSet), 64'd0);
  endtask

  // Drive a request at a falling edge, check the result at the next falling edge.
  task automatic doReturn(input logic [MODE_W-1:0] cm, input logic [PLV_W:0] op,
      input logic [ADDR_W-1:0] oa, input logic [PLV_W:0] rp, input logic [ADDR_W-1:0] ra);
    logic fl = ra[0];
    logic ok = (cm[PLV_W-1:0] == '0);
    curMode = cm; ordPrev = op; ordAddr = oa; refillPrev = rp; refillAddr = ra;
    retReq = 1'b1;
    @(negedge clk);
    retReq = 1'b0;
    check("R8 commit strobe", 64'(commitValid), 64'(ok));
    check("R7 fault strobe", 64'(faultValid), 64'(!ok));
    check("R5 llSet", 64'(llSet), 64'(ok));
    check("R9 exclusive", 64'(commitValid && faultValid), 64'd0);
    if (ok) begin
      check(fl ? "R2 refill mode" : "R4 ordinary mode", 64'(modeOut[PLV_W:0]),
            64'(expMode(cm, op, rp, fl) & 9'h7));
      check("R6 upper mode bits", 64'(modeOut), 64'(expMode(cm, op, rp, fl)));
      check(fl ? "R3 refill we" : "R4 no refill we", 64'(refillAddrWe), 64'(fl));
      check(fl ? "R3 redirect" : "R4 redirect", 64'(redirectPc),
            64'(fl ? {ra[ADDR_W-1:1], 1'b0} : oa));
      if (fl) check("R3 refill writeback", 64'(refillAddrOut), 64'({ra[ADDR_W-1:1], 1'b0}));
    end else begin
      check("R7 no refill we", 64'(refillAddrWe), 64'd0);
    end
    @(negedge clk);
    checkIdle("R8 gap");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    retReq = 1'b1;
    @(negedge clk);
    checkIdle("R1 in reset");
    retReq = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset");

    // Directed corners
    doReturn(9'h1F8, 3'b101, 32'h0000_1000, 3'b010, 32'h8000_0041); // refill
    doReturn(9'h1F8, 3'b101, 32'h0000_1000, 3'b010, 32'h8000_0040); // ordinary
    doReturn(9'h003, 3'b000, 32'h0000_2000, 3'b111, 32'hFFFF_FFFF); // fault
    doReturn(9'h1FC, 3'b011, 32'hFFFF_FFFC, 3'b100, 32'h0000_0001); // refill, addr 0
    doReturn(9'h0A9, 3'b000, 32'h1234_5678, 3'b000, 32'h0000_0000); // fault plv 1

    // Back-to-back requests
    curMode = 9'h040; ordPrev = 3'b111; ordAddr = 32'hA0; refillPrev = 3'b001;
    refillAddr = 32'hB1; retReq = 1'b1;
    @(negedge clk);
    check("R8 b2b first", 64'(commitValid), 64'd1);
    check("R3 b2b pc", 64'(redirectPc), 64'hB0);
    refillAddr = 32'hB0;
    @(negedge clk);
    retReq = 1'b0;
    check("R8 b2b second", 64'(commitValid), 64'd1);
    check("R4 b2b pc", 64'(redirectPc), 64'hA0);
    check("R4 b2b we", 64'(refillAddrWe), 64'd0);
    @(negedge clk);
    checkIdle("R8 b2b idle");

    // Constrained random
    for (int i = 0; i < 300; i++) begin
      logic [MODE_W-1:0] cm = MODE_W'($urandom);
      if ($urandom_range(0, 3) != 0) cm[PLV_W-1:0] = '0;
      doReturn(cm, 3'($urandom), $urandom, 3'($urandom), $urandom);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule